// File: doc/BRIEF.md
# Receive Character Timeout Detector

This block watches a receive FIFO and raises a timeout flag when data has been sitting in it with no traffic for a long while. It counts 16x baud tick enables while the FIFO holds at least one character, FIFO mode is on, and nothing is written into or taken out of the FIFO. Once the quiet period reaches four character times, it raises the flag. The interrupt logic then uses the flag to tell software to collect a short tail of data that never reached the FIFO trigger level.

The length of one character time is fixed at the longest frame the line can carry: 1 start, 8 data, 1 parity and 2 stop bits, which is 12 bit times. The word length, parity and stop-bit settings do not change it. With 16 ticks per bit, the threshold is 4 × 12 × 16 = 768 ticks. Any of the following clears the count and the flag: a FIFO write, a FIFO read, an empty FIFO, FIFO mode being off, or a read of the receive buffer.

The counter stops at the threshold. The flag therefore stays high until one of those events clears it. The FIFO storage and the interrupt priority encoding are not part of this block.

Top module: `rx_char_timeout`

## Requirements
- R1: After a synchronous active-low reset, `timeout` is 0.
- R2: With FIFO mode on, the FIFO non-empty, and no push, pop or buffer read, `timeout` stays 0 after 767 tick enables. It becomes 1 one clock after the 768th tick enable (4 characters × 12 bits × 16 ticks).
- R3: A push into the FIFO clears `timeout` and restarts the count from zero, so 768 further ticks are needed after the push.
- R4: A pop from the FIFO clears `timeout` and restarts the count from zero.
- R5: While `rx_nonempty` is 0, `timeout` is 0 one clock later, however many ticks arrive.
- R6: A receive buffer read (`rbr_rd` = 1) clears `timeout` and restarts the count, so 768 further ticks are needed before it rises again.
- R7: Once `timeout` is 1, further tick enables keep it at 1 (the count saturates) until a clearing event occurs.
- R8: While `fifo_en` is 0, `timeout` is 0 one clock later, and ticks are not counted.
- R9: Clock cycles with `tick16` = 0 do not advance the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en | input | 1 | FIFO mode enabled |
| tick16 | input | 1 | 16x baud tick enable, one clock wide |
| rx_push | input | 1 | Character written into the receive FIFO |
| rx_pop | input | 1 | Character taken from the receive FIFO |
| rx_nonempty | input | 1 | Receive FIFO holds at least one character |
| rbr_rd | input | 1 | Receive buffer register read strobe |
| timeout | output | 1 | Character timeout indication |

## Verification
The assertions check the following on every cycle:
- every clearing event (push, pop, buffer read, empty FIFO, FIFO mode off) zeroes the count and drops the flag on the next clock;
- the count moves by exactly one per tick and holds without a tick;
- the count never passes the threshold;
- the flag rises only from a saturated count.

Only the bench's scenarios can show that the threshold is exactly 768 ticks and not 767. They also show that a restart in mid-count really demands a full new window, and that a long run of tick-free cycles leaves the count where it was.

// File: rtl/rxto_pkg.sv
// Package: shared sizing for the receive character timeout detector.
// Assumes a fixed worst-case frame and a 16x tick; all counts derive here.
package rxto_pkg;
    parameter int unsigned TICKS_PER_BIT  = 16;
    parameter int unsigned BITS_PER_CHAR  = 12;
    parameter int unsigned CHARS_TO_WAIT  = 4;
    parameter int unsigned LIMIT_DEFAULT  = TICKS_PER_BIT * BITS_PER_CHAR * CHARS_TO_WAIT;
endpackage

// File: rtl/rxto_restart.sv
// Module: rxto_restart
// Merges every event that must restart the quiet window into one strobe.
// Assumes all inputs are synchronous to the counter clock.
module rxto_restart (
    input  logic fifo_en,
    input  logic rx_push,
    input  logic rx_pop,
    input  logic rx_nonempty,
    input  logic rbr_rd,
    output logic restart
);
    // Purpose: any traffic, an empty FIFO, a read or disabled mode restarts.
    always_comb begin
        restart = !fifo_en || !rx_nonempty || rx_push || rx_pop || rbr_rd;
    end
endmodule

// File: rtl/rxto_sat_counter.sv
// Module: rxto_sat_counter
// Counts tick enables up to LIMIT and then holds there.
// Assumes restart has priority over a tick in the same cycle.
module rxto_sat_counter #(
    parameter int unsigned LIMIT = 768,
    parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    // Purpose: clear on restart, otherwise step on tick until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (tick && (count != TOP)) begin
            count <= count + CW'(1);
        end
    end
endmodule

// File: rtl/rxto_flag_stage.sv
// Module: rxto_flag_stage
// Registers the timeout flag from the saturated count.
// Assumes the count holds at LIMIT, so the flag persists until restart.
module rxto_flag_stage #(
    parameter int unsigned LIMIT = 768,
    parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] count,
    output logic          flag
);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    // Purpose: flag follows a full window unless a restart is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= !restart && (count == TOP);
        end
    end
endmodule

// File: rtl/rx_char_timeout.sv
// Module: rx_char_timeout (top)
// Raises timeout after CHARS character times of a non-empty, idle receive FIFO.
// Assumes tick16 is a one-clock enable at 16x the bit rate and that the
// character time is fixed at the worst-case frame length.
module rx_char_timeout #(
    parameter int unsigned TICKS_PER_BIT = rxto_pkg::TICKS_PER_BIT,
    parameter int unsigned BITS_PER_CHAR = rxto_pkg::BITS_PER_CHAR,
    parameter int unsigned CHARS         = rxto_pkg::CHARS_TO_WAIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_en,
    input  logic tick16,
    input  logic rx_push,
    input  logic rx_pop,
    input  logic rx_nonempty,
    input  logic rbr_rd,
    output logic timeout
);
    localparam int unsigned THRESH = TICKS_PER_BIT * BITS_PER_CHAR * CHARS;
    localparam int unsigned CW     = $clog2(THRESH + 1);

    logic          restart;
    logic [CW-1:0] cnt_q;

    rxto_restart u_restart (
        .fifo_en     (fifo_en),
        .rx_push     (rx_push),
        .rx_pop      (rx_pop),
        .rx_nonempty (rx_nonempty),
        .rbr_rd      (rbr_rd),
        .restart     (restart)
    );

    rxto_sat_counter #(.LIMIT(THRESH), .CW(CW)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick16),
        .count   (cnt_q)
    );

    rxto_flag_stage #(.LIMIT(THRESH), .CW(CW)) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .count   (cnt_q),
        .flag    (timeout)
    );
endmodule

// File: rtl/rx_char_timeout_chk.sv
// Module: rx_char_timeout_chk
// Cycle-level properties of the timeout detector, bound into the top.
module rx_char_timeout_chk #(
    parameter int unsigned THRESH = 768,
    parameter int unsigned CW     = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          tick16,
    input logic          rx_nonempty,
    input logic          rbr_rd,
    input logic          restart,
    input logic [CW-1:0] cnt,
    input logic          timeout
);
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0 && !timeout)); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(THRESH)); // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && tick16 && cnt != CW'(THRESH)) |=> cnt == CW'($past(cnt) + 1'b1)); // R2
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !tick16) |=> $stable(cnt)); // R9
    AST_EMPTY_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_nonempty |=> !timeout); // R5
    AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> !timeout); // R8
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rbr_rd |=> !timeout); // R6
    AST_RISE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(cnt) == CW'(THRESH)); // R2
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !restart) |=> timeout); // R7
endmodule

bind rx_char_timeout rx_char_timeout_chk #(.THRESH(THRESH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .tick16      (tick16),
    .rx_nonempty (rx_nonempty),
    .rbr_rd      (rbr_rd),
    .restart     (restart),
    .cnt         (cnt_q),
    .timeout     (timeout)
);

// File: tb/rx_char_timeout_test.sv
// Directed bench: one task per scenario, each checking its own results.
module rx_char_timeout_test;
    localparam int LIMIT = 768;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b0;
    logic tick16 = 1'b0;
    logic rx_push = 1'b0;
    logic rx_pop = 1'b0;
    logic rx_nonempty = 1'b0;
    logic rbr_rd = 1'b0;
    logic timeout;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rx_char_timeout uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tick16(tick16),
        .rx_push(rx_push), .rx_pop(rx_pop), .rx_nonempty(rx_nonempty),
        .rbr_rd(rbr_rd), .timeout(timeout)
    );

    task automatic check(input logic exp, input string req);
        checks++;
        if (timeout !== exp) begin
            errors++;
            $display("FAIL %s: timeout=%b expected %b at %0t", req, timeout, exp, $time);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick16 = 1'b1;
        end
        @(negedge clk); tick16 = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // which: 0 push, 1 pop, 2 buffer read
    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) rx_push = 1'b1;
        else if (which == 1) rx_pop = 1'b1;
        else rbr_rd = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; rx_pop = 1'b0; rbr_rd = 1'b0;
    endtask

    task automatic arm();
        fifo_en = 1'b1; rx_nonempty = 1'b1;
        pulse(1);
    endtask

    task automatic t_reset();
        idle(2);
        check(1'b0, "R1 reset");
    endtask

    task automatic t_threshold();
        arm();
        ticks(LIMIT - 1); idle(3);
        check(1'b0, "R2 767 ticks");
        ticks(1); idle(3);
        check(1'b1, "R2 768 ticks");
    endtask

    task automatic t_restart(input int which, input string req);
        arm();
        ticks(700);
        pulse(which); idle(2);
        ticks(700); idle(3);
        check(1'b0, req);
        ticks(LIMIT - 700 - 1); idle(3);
        check(1'b0, req);
        ticks(1); idle(3);
        check(1'b1, req);
        pulse(which); idle(2);
        check(1'b0, req);
    endtask

    task automatic t_empty();
        arm();
        rx_nonempty = 1'b0;
        ticks(1000); idle(3);
        check(1'b0, "R5 empty no count");
        rx_nonempty = 1'b1;
        ticks(LIMIT); idle(3);
        check(1'b1, "R5 refilled");
        @(negedge clk); rx_nonempty = 1'b0;
        idle(2);
        check(1'b0, "R5 empty clears");
        rx_nonempty = 1'b1;
    endtask

    task automatic t_read();
        arm();
        ticks(LIMIT); idle(3);
        check(1'b1, "R6 setup");
        pulse(2); idle(2);
        check(1'b0, "R6 read clears");
        ticks(LIMIT - 1); idle(3);
        check(1'b0, "R6 full window after read");
        ticks(1); idle(3);
        check(1'b1, "R6 rises after new window");
    endtask

    task automatic t_sat();
        arm();
        ticks(LIMIT); idle(3);
        ticks(2000); idle(3);
        check(1'b1, "R7 saturated hold");
    endtask

    task automatic t_mode();
        arm();
        fifo_en = 1'b0;
        ticks(1000); idle(3);
        check(1'b0, "R8 mode off no count");
        fifo_en = 1'b1;
        ticks(LIMIT); idle(3);
        check(1'b1, "R8 mode on counts");
        @(negedge clk); fifo_en = 1'b0;
        idle(2);
        check(1'b0, "R8 mode off clears");
        fifo_en = 1'b1;
    endtask

    task automatic t_idle();
        arm();
        ticks(LIMIT - 1);
        idle(500);
        check(1'b0, "R9 no ticks no advance");
        ticks(1); idle(3);
        check(1'b1, "R9 final tick");
    endtask

    initial begin
        fork
            begin
                idle(3);
                @(negedge clk); rst_n = 1'b1;
                t_reset();
                t_threshold();
                t_restart(0, "R3 push restart");
                t_restart(1, "R4 pop restart");
                t_empty();
                t_read();
                t_sat();
                t_mode();
                t_idle();
            end
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule